// File: doc/BRIEF.md
# Single-Channel DMA Mover

This block is a one-channel direct-memory-access engine. Software programs it through a small word-addressed register window. It sets the identity of the peripheral being served, the direction of the move, the first memory address and the length in bytes. A write with the go bit set then launches the transfer. From that point the engine raises a request toward a central bus arbiter. In every cycle in which the arbiter grants the bus, it moves one word between the peripheral's data port and memory.

The memory side is a plain synchronous bus with no wait states. In a cycle where `mem_valid` is high, the address, the command and any write data are valid, and read data is returned in that same cycle. The peripheral side has a pop strobe with incoming data and a push strobe with outgoing data. At the end of the transfer the engine drops its request, goes back to idle and raises an interrupt. The interrupt stays high until software clears it. A zero-length launch finishes at once and never touches the bus.

Top module: `dma_mover`

## Requirements
- R1: Offsets 1, 2 and 3 hold the peripheral identity, the first memory address and the byte length, and each reads back what was last written to it. After reset all read as zero.
- R2: Bit 1 of the control register at offset 0 selects the direction. With 0 (peripheral to memory), every transfer cycle has `mem_write`=1 and `dev_pop`=1, and `mem_wdata` equals `dev_rdata`.
- R3: With direction 1 (memory to peripheral), every transfer cycle has `mem_write`=0 and `dev_push`=1, and `dev_wdata` equals `mem_rdata` of that cycle.
- R4: While a transfer is pending, `bus_req` is high. `mem_valid` is never high without `bus_gnt`, and every cycle with both `bus_req` and `bus_gnt` high is a transfer cycle.
- R5: While busy, writes to offsets 0 to 3 are ignored, including a new go. Bit 0 of the status register at offset 4 reads 1 while busy.
- R6: The first transfer uses the programmed address. Each following one adds the word size in bytes (4 by default). The number of transfers is the byte length divided by the word size, rounded up.
- R7: Completion sets the interrupt, which also reads as status bit 1. It stays set until a write to offset 4 with bit 1 equal to 1.
- R8: `bus_req` and busy fall at the same clock edge where the interrupt rises after the last word.
- R9: A go with byte length zero sets the interrupt at that edge and never raises `bus_req`.
- R10: `dev_sel` always presents the programmed peripheral identity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | synchronous active-low reset |
| cfg_we | input | 1 | register write strobe |
| cfg_addr | input | 3 | register offset, for writes and for the combinational read |
| cfg_wdata | input | 32 | register write data |
| cfg_rdata | output | 32 | register read data for `cfg_addr` |
| bus_req | output | 1 | bus request to the arbiter |
| bus_gnt | input | 1 | bus grant from the arbiter |
| mem_valid | output | 1 | memory cycle active |
| mem_write | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | ADDR_W | memory byte address |
| mem_wdata | output | DATA_W | memory write data |
| mem_rdata | input | DATA_W | memory read data, same cycle |
| dev_sel | output | DEV_W | identity of the served peripheral |
| dev_pop | output | 1 | take one word from the peripheral |
| dev_rdata | input | DATA_W | word offered by the peripheral |
| dev_push | output | 1 | give one word to the peripheral |
| dev_wdata | output | DATA_W | word handed to the peripheral |
| irq | output | 1 | completion interrupt |

## Verification
The properties assume that the arbiter grants only in answer to a request, so a grant with no request pending is simply unused. They also assume that software does not launch a new transfer in the edge where it clears the interrupt. The stimulus keeps the grant low outside a monitored transfer and clears the interrupt only after the engine is idle. Within a transfer, the grant follows continuous, every-third-cycle-off and alternating patterns, so that the address stepping is checked across stalls.

// File: rtl/dma_mover_pkg.sv
`timescale 1ns/1ps
// Shared register offsets, bit positions and sequencer state type for the
// DMA mover. Assumes a 32-bit register window addressed by word offset.
package dma_mover_pkg;
    localparam int CFG_W  = 32;
    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] OFS_CTRL = 3'd0;
    localparam logic [REG_AW-1:0] OFS_DEV  = 3'd1;
    localparam logic [REG_AW-1:0] OFS_BASE = 3'd2;
    localparam logic [REG_AW-1:0] OFS_LEN  = 3'd3;
    localparam logic [REG_AW-1:0] OFS_STAT = 3'd4;

    localparam int BIT_GO   = 0;
    localparam int BIT_DIR  = 1;
    localparam int BIT_BUSY = 0;
    localparam int BIT_IRQ  = 1;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_MOVE = 1'b1
    } seq_state_t;
endpackage

// File: rtl/dma_mover_regs.sv
`timescale 1ns/1ps
// Register window of the DMA mover: holds direction, peripheral identity,
// base address and byte length, produces the go pulse and keeps the sticky
// interrupt flag. Assumes busy and done come from the sequencer.
module dma_mover_regs
    import dma_mover_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 12,
    parameter int DEV_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [REG_AW-1:0] cfg_addr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic              busy,
    input  logic              done,
    output logic              go,
    output logic              dir_q,
    output logic [DEV_W-1:0]  dev_q,
    output logic [ADDR_W-1:0] base_q,
    output logic [CNT_W-1:0]  len_q,
    output logic              irq_q
);
    logic cfg_open;
    logic irq_clear;
    logic unused_wdata;

    assign cfg_open     = cfg_we && !busy;
    assign irq_clear    = cfg_we && (cfg_addr == OFS_STAT) && cfg_wdata[BIT_IRQ];
    assign go           = cfg_open && (cfg_addr == OFS_CTRL) && cfg_wdata[BIT_GO];
    assign unused_wdata = ^cfg_wdata;

    // Configuration registers: loaded only while the engine is idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= 1'b0;
            dev_q  <= '0;
            base_q <= '0;
            len_q  <= '0;
        end else if (cfg_open) begin
            case (cfg_addr)
                OFS_CTRL: dir_q  <= cfg_wdata[BIT_DIR];
                OFS_DEV:  dev_q  <= cfg_wdata[DEV_W-1:0];
                OFS_BASE: base_q <= cfg_wdata[ADDR_W-1:0];
                OFS_LEN:  len_q  <= cfg_wdata[CNT_W-1:0];
                default:  ;
            endcase
        end
    end

    // Sticky completion flag: set on done, cleared by software, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (done) begin
            irq_q <= 1'b1;
        end else if (irq_clear) begin
            irq_q <= 1'b0;
        end
    end

    // Combinational readback of the addressed register.
    always_comb begin
        case (cfg_addr)
            OFS_CTRL: cfg_rdata = CFG_W'({dir_q, 1'b0});
            OFS_DEV:  cfg_rdata = CFG_W'(dev_q);
            OFS_BASE: cfg_rdata = CFG_W'(base_q);
            OFS_LEN:  cfg_rdata = CFG_W'(len_q);
            OFS_STAT: cfg_rdata = CFG_W'({irq_q, busy});
            default:  cfg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dma_mover_seq.sv
`timescale 1ns/1ps
// Transfer sequencer: turns the go pulse into a word count, requests the
// bus, advances address and count on each granted cycle and flags the end.
// Assumes WORD_BYTES is a power of two and the grant may drop at any cycle.
module dma_mover_seq
    import dma_mover_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int CNT_W      = 12,
    parameter int WORD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [ADDR_W-1:0] base,
    input  logic [CNT_W-1:0]  len,
    input  logic              bus_gnt,
    output logic              busy,
    output logic              bus_req,
    output logic              beat,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              done
);
    localparam int SHIFT = $clog2(WORD_BYTES);

    seq_state_t       state;
    logic [CNT_W:0]   len_round;
    logic [CNT_W-1:0] words;
    logic [CNT_W-1:0] left;
    logic             last;

    assign len_round = {1'b0, len} + (CNT_W+1)'(WORD_BYTES - 1);
    assign words     = CNT_W'(len_round >> SHIFT);
    assign busy      = (state == SEQ_MOVE);
    assign bus_req   = busy;
    assign beat      = busy && bus_gnt;
    assign last      = (left == CNT_W'(1));
    assign done      = (go && (words == '0)) || (beat && last);

    // State, address and word counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SEQ_IDLE;
            cur_addr <= '0;
            left     <= '0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (go && (words != '0)) begin
                        state    <= SEQ_MOVE;
                        cur_addr <= base;
                        left     <= words;
                    end
                end
                SEQ_MOVE: begin
                    if (beat) begin
                        cur_addr <= cur_addr + ADDR_W'(WORD_BYTES);
                        left     <= left - CNT_W'(1);
                        if (last) begin
                            state <= SEQ_IDLE;
                        end
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dma_mover_port.sv
`timescale 1ns/1ps
// Data steering between the peripheral port and the memory bus for one
// transfer cycle. Assumes zero-wait memory: read data is valid in the
// cycle of the request.
module dma_mover_port #(
    parameter int DATA_W = 32
) (
    input  logic              beat,
    input  logic              dir,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] dev_rdata,
    output logic              mem_valid,
    output logic              mem_write,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              dev_pop,
    output logic              dev_push,
    output logic [DATA_W-1:0] dev_wdata
);
    // Route one word per transfer cycle according to the direction bit.
    always_comb begin
        mem_valid = beat;
        mem_write = beat && !dir;
        dev_pop   = beat && !dir;
        dev_push  = beat && dir;
        mem_wdata = (beat && !dir) ? dev_rdata : '0;
        dev_wdata = (beat && dir)  ? mem_rdata : '0;
    end
endmodule

// File: rtl/dma_mover.sv
`timescale 1ns/1ps
// Top of the single-channel DMA mover: register window, sequencer with bus
// request, and data steering. Assumes a central arbiter drives bus_gnt.
module dma_mover
    import dma_mover_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 32,
    parameter int CNT_W      = 12,
    parameter int DEV_W      = 4,
    parameter int WORD_BYTES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              mem_valid,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DEV_W-1:0]  dev_sel,
    output logic              dev_pop,
    input  logic [DATA_W-1:0] dev_rdata,
    output logic              dev_push,
    output logic [DATA_W-1:0] dev_wdata,
    output logic              irq
);
    logic              busy;
    logic              done;
    logic              go;
    logic              beat;
    logic              dir_q;
    logic [ADDR_W-1:0] base_q;
    logic [CNT_W-1:0]  len_q;

    dma_mover_regs #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DEV_W(DEV_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata),
        .busy(busy), .done(done), .go(go),
        .dir_q(dir_q), .dev_q(dev_sel), .base_q(base_q), .len_q(len_q),
        .irq_q(irq)
    );

    dma_mover_seq #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .WORD_BYTES(WORD_BYTES)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .go(go), .base(base_q), .len(len_q), .bus_gnt(bus_gnt),
        .busy(busy), .bus_req(bus_req), .beat(beat),
        .cur_addr(mem_addr), .done(done)
    );

    dma_mover_port #(
        .DATA_W(DATA_W)
    ) u_port (
        .beat(beat), .dir(dir_q),
        .mem_rdata(mem_rdata), .dev_rdata(dev_rdata),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_wdata(mem_wdata),
        .dev_pop(dev_pop), .dev_push(dev_push), .dev_wdata(dev_wdata)
    );
endmodule

// File: rtl/dma_mover_chk.sv
`timescale 1ns/1ps
// Property checker for the DMA mover, attached to every instance by bind.
// Assumes the arbiter grants only after a request.
module dma_mover_chk #(
    parameter int ADDR_W     = 16,
    parameter int CNT_W      = 12,
    parameter int WORD_BYTES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [2:0]        cfg_addr,
    input logic [31:0]       cfg_wdata,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic              mem_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              irq,
    input logic              busy,
    input logic              go,
    input logic [ADDR_W-1:0] base_q,
    input logic [CNT_W-1:0]  len_q
);
    logic clr_wr;
    assign clr_wr = cfg_we && (cfg_addr == 3'd4) && cfg_wdata[1];

    // R4: a memory cycle needs both the request and the grant
    p_beat_needs_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (bus_gnt && bus_req));

    // R5: configuration frozen while a transfer is pending
    p_cfg_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(len_q) && $stable(base_q)));

    // R6: back-to-back transfer cycles step by one word
    p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |=> (!mem_valid || (mem_addr == $past(mem_addr) + ADDR_W'(WORD_BYTES))));

    // R7: interrupt holds until a clearing write
    p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_wr) |=> irq);

    // R8: request is gone once the interrupt rises
    p_req_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> !bus_req);

    // R9: zero-length launch ends without requesting the bus
    p_zero_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (go && (len_q == '0)) |=> (irq && !bus_req));
endmodule

bind dma_mover dma_mover_chk #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .WORD_BYTES(WORD_BYTES)
) u_chk (.*);

// File: tb/dma_mover_bench.sv
`timescale 1ns/1ps
module dma_mover_bench;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 12;
    localparam int DEV_W  = 4;
    localparam int WB     = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [2:0]        cfg_addr = 3'd0;
    logic [31:0]       cfg_wdata = '0;
    logic [31:0]       cfg_rdata;
    logic              bus_req;
    logic              bus_gnt = 1'b0;
    logic              mem_valid;
    logic              mem_write;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata;
    logic [DEV_W-1:0]  dev_sel;
    logic              dev_pop;
    logic [DATA_W-1:0] dev_rdata;
    logic              dev_push;
    logic [DATA_W-1:0] dev_wdata;
    logic              irq;

    logic [DATA_W-1:0] mem_model [0:255];
    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    assign mem_rdata = mem_model[mem_addr[9:2]];
    assign dev_rdata = {dev_sel, 12'h000, mem_addr};

    dma_mover u_dma_mover (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata),
        .bus_req(bus_req), .bus_gnt(bus_gnt),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .dev_sel(dev_sel), .dev_pop(dev_pop), .dev_rdata(dev_rdata),
        .dev_push(dev_push), .dev_wdata(dev_wdata), .irq(irq)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    function automatic logic grant_of(input int mode, input int cyc);
        case (mode)
            0: return 1'b1;
            1: return (cyc % 3) != 0;
            default: return (cyc % 2) == 0;
        endcase
    endfunction

    // Observe one launched transfer until its interrupt, then clear it.
    task automatic watch(input logic d, input logic [3:0] dv, input logic [15:0] base,
                         input int len, input int gmode);
        int k = 0;
        int want = (len + WB - 1) / WB;
        int guard = 0;
        bit fin = 0;
        logic [15:0] ea;
        logic [31:0] r;
        while (!fin && guard < 300) begin
            @(posedge clk); #1;
            guard++;
            bus_gnt = grant_of(gmode, guard);
            @(negedge clk);
            if (irq) begin
                fin = 1;
                check(bus_req == 1'b0, "R8 request low at irq", {31'd0, bus_req}, 0);
                check(mem_valid == 1'b0, "R8 no cycle at irq", {31'd0, mem_valid}, 0);
                if (len == 0) check(guard == 1, "R9 immediate completion", guard, 1);
            end else begin
                check(bus_req == 1'b1, "R4 request while pending", {31'd0, bus_req}, 1);
                if (mem_valid) begin
                    ea = base + 16'(WB * k);
                    check(bus_gnt == 1'b1, "R4 cycle without grant", {31'd0, bus_gnt}, 1);
                    check(mem_addr == ea, "R6 address", {16'd0, mem_addr}, {16'd0, ea});
                    if (!d) begin
                        check(mem_write && dev_pop && !dev_push, "R2 strobes",
                              {29'd0, mem_write, dev_pop, dev_push}, 32'h6);
                        check(mem_wdata == {dv, 12'h000, ea}, "R2 data",
                              mem_wdata, {dv, 12'h000, ea});
                    end else begin
                        check(!mem_write && dev_push && !dev_pop, "R3 strobes",
                              {29'd0, mem_write, dev_pop, dev_push}, 32'h1);
                        check(dev_wdata == mem_model[ea[9:2]], "R3 data",
                              dev_wdata, mem_model[ea[9:2]]);
                    end
                    k++;
                end else if (bus_gnt) begin
                    check(1'b0, "R4 granted cycle unused", 0, 1);
                end
            end
        end
        bus_gnt = 1'b0;
        check(fin, "R7 interrupt raised", {31'd0, fin}, 1);
        check(k == want, "R6 word count", k, want);
        rd(3'd4, r);
        check(r == 32'h2, "R8 status idle with irq", r, 32'h2);
        repeat (3) @(negedge clk);
        check(irq == 1'b1, "R7 interrupt held", {31'd0, irq}, 1);
        wr(3'd4, 32'h2);
        check(irq == 1'b0, "R7 interrupt cleared", {31'd0, irq}, 0);
    endtask

    task automatic launch(input logic d, input logic [3:0] dv, input logic [15:0] base,
                          input int len);
        logic [31:0] r;
        wr(3'd1, {28'd0, dv});
        wr(3'd2, {16'd0, base});
        wr(3'd3, 32'(len));
        rd(3'd1, r); check(r == {28'd0, dv}, "R1 identity readback", r, {28'd0, dv});
        rd(3'd2, r); check(r == {16'd0, base}, "R1 base readback", r, {16'd0, base});
        rd(3'd3, r); check(r == 32'(len), "R1 length readback", r, 32'(len));
        wr(3'd0, {30'd0, d, 1'b1});
        check(dev_sel == dv, "R10 identity on port", {28'd0, dev_sel}, {28'd0, dv});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] r;
        for (int i = 0; i < 256; i++) mem_model[i] = 32'hA5000000 | 32'(i * 7);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // reset state
        @(negedge clk);
        check(!irq && !bus_req && !mem_valid, "R7 reset outputs",
              {29'd0, irq, bus_req, mem_valid}, 0);
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), r);
            check(r == 0, "R1 reset readback", r, 0);
        end

        // sweep over direction, length and grant pattern
        for (int d = 0; d < 2; d++)
            for (int len = 0; len < 14; len++)
                for (int g = 0; g < 3; g++) begin
                    launch(d[0], 4'(len + g), 16'h0040 + 16'(len * 64), len);
                    watch(d[0], 4'(len + g), 16'h0040 + 16'(len * 64), len, g);
                end

        // writes while busy are ignored
        launch(1'b0, 4'd3, 16'h0200, 8);
        rd(3'd4, r); check(r[0] == 1'b1, "R5 busy flag", r, 32'h1);
        wr(3'd1, 32'h9);
        wr(3'd2, 32'h0300);
        wr(3'd3, 32'd40);
        wr(3'd0, 32'h3);
        rd(3'd1, r); check(r == 32'h3, "R5 identity frozen", r, 32'h3);
        rd(3'd2, r); check(r == 32'h0200, "R5 base frozen", r, 32'h0200);
        rd(3'd3, r); check(r == 32'd8, "R5 length frozen", r, 32'd8);
        rd(3'd0, r); check(r == 32'h0, "R5 direction frozen", r, 32'h0);
        check(dev_sel == 4'd3, "R10 identity kept", {28'd0, dev_sel}, 3);
        watch(1'b0, 4'd3, 16'h0200, 8, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule